// File: doc/BRIEF.md
# ADC Sample Window-Violation Monitor

This block watches a stream of parallel ADC conversion results, arriving one per sample strobe, and judges each sample on its own against an acceptance window. The window is set by a centre code and a half-width. A sample that falls inside the window, edges included, is dropped without any output. A sample that falls outside the window produces a single event record. The record holds the sample code, a strobe-count timestamp, a direction bit, and a flag that shows whether the record opens a new excursion or continues the one in progress. Because of this flag, downstream software can tell an isolated single-sample transient from a run of several samples without comparing timestamps.

A violation counter caps how many records are produced. When the counter reaches its programmable limit, a saturated flag rises and no further records are emitted. Long saturation of this kind is the usual sign of a functional upset rather than a transient. Monitoring starts and stops under pulse commands. Stopping keeps the count and the grouping state. A synchronous clear restarts the count, the timestamp and the grouping. The window and the limit are loaded together through one configuration strobe.

Top module: `adc_window_monitor`

## Requirements
- R1: A strobed sample with `lo <= code <= hi`, where `lo = centre - half` and `hi = centre + half` are computed without wrap, produces no record.
- R2: A strobed sample outside the window raises `rec_valid` for one cycle, one clock after the strobe edge. `rec_code` holds the sample, and `rec_above` is 1 when the code is above `hi` and 0 when it is below `lo`.
- R3: `rec_stamp` equals the number of strobes accepted while active since the last clear or reset, counted before the sample being recorded. Accepted strobes are counted whether they violate or not.
- R4: `rec_first` is 1 when the previous accepted strobe was in-window, or when there has been none since clear or reset. It is 0 when the previous accepted strobe was also a violation. Cycles without a strobe do not break an excursion.
- R5: `viol_count` increases by one for each record. `saturated` equals `viol_count >= limit`. While saturated, no record is produced.
- R6: Strobes are accepted only while `active` is 1. A `run_cmd` pulse sets `active` and a `halt_cmd` pulse clears it, with halt taking priority. Strobes while halted change nothing: no record, no timestamp step, no grouping change. Halting keeps the count.
- R7: `clear` zeroes the count, the timestamp and the grouping state on the next edge and suppresses any record for that cycle. It leaves `active` and the configuration unchanged.
- R8: `cfg_load` latches `cfg_centre`, `cfg_half` and `cfg_limit`, which take effect from the next strobe. After reset the centre is 8200, the half-width is 8 and the limit is 1000.
- R9: After reset, `active`, `rec_valid`, `saturated` and `viol_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of count, timestamp and grouping |
| run_cmd | input | 1 | Start monitoring pulse |
| halt_cmd | input | 1 | Stop monitoring pulse (wins over run) |
| cfg_load | input | 1 | Latch window and limit configuration |
| cfg_centre | input | 14 | Window centre code |
| cfg_half | input | 14 | Window half-width in codes |
| cfg_limit | input | 16 | Maximum number of records |
| sample_valid | input | 1 | Sample strobe |
| sample_code | input | 14 | Unsigned sample code |
| active | output | 1 | Monitoring running |
| saturated | output | 1 | Record limit reached |
| viol_count | output | 16 | Records emitted since clear |
| rec_valid | output | 1 | Record valid (one cycle) |
| rec_code | output | 14 | Violating sample code |
| rec_stamp | output | 32 | Strobe-count timestamp |
| rec_above | output | 1 | 1 above window, 0 below |
| rec_first | output | 1 | Record opens a new excursion |

## Verification
Every result passes through exactly one register stage. A strobe captured on edge k produces its record, its count step and its new saturation level on the outputs just after edge k. A `run_cmd`, `halt_cmd`, `clear` or `cfg_load` captured on edge k is seen in `active` or in the behaviour of the strobe at edge k+1. The bench drives all inputs at a falling edge and checks the outputs at the next falling edge, which is half a cycle after the register that captured them. It keeps its own strobe counter and grouping state, which give the expected timestamp and first-of-excursion flag.

// File: rtl/adcwm_pkg.sv
package adcwm_pkg;

   typedef enum logic {
      DIR_BELOW = 1'b0,
      DIR_ABOVE = 1'b1
   } excursion_dir_e;

   typedef enum logic [1:0] {
      STAMP_WRAP = 2'd0,
      STAMP_HOLD = 2'd1
   } stamp_mode_e;

endpackage

// File: rtl/adcwm_window_cmp.sv
module adcwm_window_cmp #(
   parameter int CODE_W = 14
) (
   input  logic [CODE_W-1:0] code,
   input  logic [CODE_W-1:0] centre,
   input  logic [CODE_W-1:0] half,
   output logic              outside,
   output adcwm_pkg::excursion_dir_e dir
);
   localparam int EXT_W = CODE_W + 1;

   logic [EXT_W-1:0] hi_edge;
   logic [EXT_W-1:0] code_plus_half;
   logic             is_above;
   logic             is_below;

   always_comb begin
      hi_edge        = {1'b0, centre} + {1'b0, half};
      code_plus_half = {1'b0, code} + {1'b0, half};
      is_above       = {1'b0, code} > hi_edge;
      is_below       = code_plus_half < {1'b0, centre};
      outside        = is_above | is_below;
      dir            = is_above ? adcwm_pkg::DIR_ABOVE : adcwm_pkg::DIR_BELOW;
   end
endmodule

// File: rtl/adcwm_stamp_ctr.sv
module adcwm_stamp_ctr #(
   parameter int                     STAMP_W = 32,
   parameter adcwm_pkg::stamp_mode_e MODE    = adcwm_pkg::STAMP_WRAP
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               step,
   output logic [STAMP_W-1:0] stamp
);
   localparam logic [STAMP_W-1:0] TOP = {STAMP_W{1'b1}};

   logic [STAMP_W-1:0] nxt;

   generate
      if (MODE == adcwm_pkg::STAMP_HOLD) begin : g_hold
         always_comb nxt = (stamp == TOP) ? stamp : stamp + 1'b1;
      end else begin : g_wrap
         always_comb nxt = stamp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    stamp <= '0;
      else if (clr)  stamp <= '0;
      else if (step) stamp <= nxt;
   end
endmodule

// File: rtl/adcwm_limit_ctr.sv
module adcwm_limit_ctr #(
   parameter int COUNT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               inc,
   input  logic [COUNT_W-1:0] limit,
   output logic [COUNT_W-1:0] count,
   output logic               full
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (clr) count <= '0;
      else if (inc) count <= count + 1'b1;
   end

   always_comb full = (count >= limit);
endmodule

// File: rtl/adc_window_monitor.sv
module adc_window_monitor #(
   parameter int                     CODE_W      = 14,
   parameter int                     STAMP_W     = 32,
   parameter int                     COUNT_W     = 16,
   parameter int                     DEF_CENTRE  = 8200,
   parameter int                     DEF_HALF    = 8,
   parameter int                     DEF_LIMIT   = 1000,
   parameter adcwm_pkg::stamp_mode_e STAMP_MODE  = adcwm_pkg::STAMP_WRAP
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               run_cmd,
   input  logic               halt_cmd,
   input  logic               cfg_load,
   input  logic [CODE_W-1:0]  cfg_centre,
   input  logic [CODE_W-1:0]  cfg_half,
   input  logic [COUNT_W-1:0] cfg_limit,
   input  logic               sample_valid,
   input  logic [CODE_W-1:0]  sample_code,
   output logic               active,
   output logic               saturated,
   output logic [COUNT_W-1:0] viol_count,
   output logic               rec_valid,
   output logic [CODE_W-1:0]  rec_code,
   output logic [STAMP_W-1:0] rec_stamp,
   output logic               rec_above,
   output logic               rec_first
);
   localparam logic [CODE_W-1:0]  RST_CENTRE = CODE_W'(DEF_CENTRE);
   localparam logic [CODE_W-1:0]  RST_HALF   = CODE_W'(DEF_HALF);
   localparam logic [COUNT_W-1:0] RST_LIMIT  = COUNT_W'(DEF_LIMIT);

   generate
      if (CODE_W < 2 || STAMP_W < 2 || COUNT_W < 1) begin : g_bad_width
         initial $fatal(1, "adc_window_monitor: width parameter too small");
      end
      if (DEF_CENTRE >= (1 << CODE_W) || DEF_HALF >= (1 << CODE_W)) begin : g_bad_window
         initial $fatal(1, "adc_window_monitor: default window exceeds code range");
      end
   endgenerate

   logic [CODE_W-1:0]  centre_q;
   logic [CODE_W-1:0]  half_q;
   logic [COUNT_W-1:0] limit_q;
   logic               prev_viol;
   logic               outside;
   adcwm_pkg::excursion_dir_e dir;
   logic [STAMP_W-1:0] stamp;
   logic               strobe;
   logic               record;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         centre_q <= RST_CENTRE;
         half_q   <= RST_HALF;
         limit_q  <= RST_LIMIT;
      end else if (cfg_load) begin
         centre_q <= cfg_centre;
         half_q   <= cfg_half;
         limit_q  <= cfg_limit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        active <= 1'b0;
      else if (halt_cmd) active <= 1'b0;
      else if (run_cmd)  active <= 1'b1;
   end

   adcwm_window_cmp #(.CODE_W(CODE_W)) u_cmp (
      .code    (sample_code),
      .centre  (centre_q),
      .half    (half_q),
      .outside (outside),
      .dir     (dir)
   );

   always_comb begin
      strobe = sample_valid & active & ~clear;
      record = strobe & outside & ~saturated;
   end

   adcwm_stamp_ctr #(.STAMP_W(STAMP_W), .MODE(STAMP_MODE)) u_stamp (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clear),
      .step  (strobe),
      .stamp (stamp)
   );

   adcwm_limit_ctr #(.COUNT_W(COUNT_W)) u_limit (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clear),
      .inc   (record),
      .limit (limit_q),
      .count (viol_count),
      .full  (saturated)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_viol <= 1'b0;
         rec_valid <= 1'b0;
         rec_code  <= '0;
         rec_stamp <= '0;
         rec_above <= 1'b0;
         rec_first <= 1'b0;
      end else if (clear) begin
         prev_viol <= 1'b0;
         rec_valid <= 1'b0;
      end else begin
         rec_valid <= record;
         if (record) begin
            rec_code  <= sample_code;
            rec_stamp <= stamp;
            rec_above <= (dir == adcwm_pkg::DIR_ABOVE);
            rec_first <= ~prev_viol;
         end
         if (strobe) prev_viol <= outside;
      end
   end
endmodule

// File: rtl/adcwm_checker.sv
module adcwm_checker #(
   parameter int CODE_W  = 14,
   parameter int COUNT_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               clear,
   input logic               cfg_load,
   input logic               halt_cmd,
   input logic               sample_valid,
   input logic               active,
   input logic               saturated,
   input logic               rec_valid,
   input logic [CODE_W-1:0]  rec_code,
   input logic [CODE_W-1:0]  centre_q,
   input logic [CODE_W-1:0]  half_q,
   input logic [COUNT_W-1:0] viol_count
);
   // R1: a record never carries an in-window code
   p_outside_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> (({1'b0, rec_code} > ({1'b0, $past(centre_q)} + {1'b0, $past(half_q)})) ||
                     (({1'b0, rec_code} + {1'b0, $past(half_q)}) < {1'b0, $past(centre_q)})));

   // R2: a record follows a strobe
   p_rec_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> $past(sample_valid));

   // R5: each record advances the count by one
   p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> (viol_count == $past(viol_count) + 1'b1));

   // R5: nothing is recorded while saturated
   p_sat_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (saturated && !clear && !cfg_load) |=> !rec_valid);

   // R6: halt stops monitoring
   p_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      halt_cmd |=> !active);

   // R6: no record while inactive
   p_idle_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !rec_valid);

   // R7: clear empties the counter and suppresses the record
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (viol_count == '0 && !rec_valid));
endmodule

bind adc_window_monitor adcwm_checker #(.CODE_W(CODE_W), .COUNT_W(COUNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .clear        (clear),
   .cfg_load     (cfg_load),
   .halt_cmd     (halt_cmd),
   .sample_valid (sample_valid),
   .active       (active),
   .saturated    (saturated),
   .rec_valid    (rec_valid),
   .rec_code     (rec_code),
   .centre_q     (centre_q),
   .half_q       (half_q),
   .viol_count   (viol_count)
);

// File: tb/sim_adc_window_monitor.sv
module sim_adc_window_monitor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clear = 1'b0, run_cmd = 1'b0, halt_cmd = 1'b0, cfg_load = 1'b0;
   logic [13:0] cfg_centre = 14'd8200, cfg_half = 14'd8;
   logic [15:0] cfg_limit = 16'd1000;
   logic        sample_valid = 1'b0;
   logic [13:0] sample_code = '0;
   logic        active, saturated, rec_valid, rec_above, rec_first;
   logic [15:0] viol_count;
   logic [13:0] rec_code;
   logic [31:0] rec_stamp;

   int errors = 0;
   int checks = 0;
   int strobes = 0;   // bench model of the timestamp
   int nrec = 0;      // bench model of the count
   bit done = 0;

   always #5 clk = ~clk;

   adc_window_monitor u0 (.*);

   // {valid, code, expect_record, expect_first, expect_above}
   localparam logic [17:0] VEC [12] = '{
      {1'b1, 14'd8200,  1'b0, 1'b0, 1'b0},
      {1'b1, 14'd8192,  1'b0, 1'b0, 1'b0},
      {1'b1, 14'd8208,  1'b0, 1'b0, 1'b0},
      {1'b1, 14'd8209,  1'b1, 1'b1, 1'b1},
      {1'b1, 14'd8210,  1'b1, 1'b0, 1'b1},
      {1'b1, 14'd8191,  1'b1, 1'b0, 1'b0},
      {1'b1, 14'd8200,  1'b0, 1'b0, 1'b0},
      {1'b1, 14'd8191,  1'b1, 1'b1, 1'b0},
      {1'b0, 14'd0,     1'b0, 1'b0, 1'b0},
      {1'b1, 14'd0,     1'b1, 1'b0, 1'b0},
      {1'b1, 14'd16383, 1'b1, 1'b0, 1'b1},
      {1'b1, 14'd8205,  1'b0, 1'b0, 1'b0}
   };

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk(input string tag, input longint act, input longint exp);
      check(act == exp, tag, act, exp);
   endtask

   // drive one cycle at a falling edge, outputs examined at the next falling edge
   task automatic step(input bit v, input logic [13:0] c);
      sample_valid = v;
      sample_code  = c;
      @(negedge clk);
      sample_valid = 1'b0;
   endtask

   task automatic pulse_clear();
      clear = 1'b1; @(negedge clk); clear = 1'b0;
      strobes = 0; nrec = 0;
   endtask

   task automatic load(input logic [13:0] c, input logic [13:0] h, input logic [15:0] l);
      cfg_centre = c; cfg_half = h; cfg_limit = l;
      cfg_load = 1'b1; @(negedge clk); cfg_load = 1'b0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=1 expected=0");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 active", active, 0);
      chk("R9 rec_valid", rec_valid, 0);
      chk("R9 saturated", saturated, 0);
      chk("R9 viol_count", viol_count, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R6: inactive monitor ignores violations
      step(1, 14'd9000);
      chk("R6 idle no record", rec_valid, 0);
      chk("R6 idle count", viol_count, 0);

      run_cmd = 1'b1; @(negedge clk); run_cmd = 1'b0;
      chk("R6 run sets active", active, 1);

      // R1..R4, R8 defaults: table walk
      for (int i = 0; i < 12; i++) begin
         logic [17:0] e;
         e = VEC[i];
         step(e[17], e[16:3]);
         chk($sformatf("R1/R2 vec%0d rec_valid", i), rec_valid, e[2]);
         if (e[2]) begin
            nrec++;
            chk($sformatf("R2 vec%0d code", i), rec_code, e[16:3]);
            chk($sformatf("R2 vec%0d above", i), rec_above, e[0]);
            chk($sformatf("R3 vec%0d stamp", i), rec_stamp, strobes);
            chk($sformatf("R4 vec%0d first", i), rec_first, e[1]);
         end
         chk($sformatf("R5 vec%0d count", i), viol_count, nrec);
         if (e[17]) strobes++;
      end

      // R5 saturation at limit 2
      pulse_clear();
      load(14'd8200, 14'd8, 16'd2);
      step(1, 14'd8300);
      chk("R5 sat rec0", rec_valid, 1);
      chk("R3 sat stamp0", rec_stamp, 0);
      step(1, 14'd8300);
      chk("R5 sat rec1", rec_valid, 1);
      chk("R4 sat first1", rec_first, 0);
      chk("R5 saturated", saturated, 1);
      step(1, 14'd8300);
      chk("R5 blocked", rec_valid, 0);
      chk("R5 count held", viol_count, 2);

      // R6 halt keeps count and state, R7 clear
      load(14'd8200, 14'd8, 16'd10);
      pulse_clear();
      chk("R7 count zero", viol_count, 0);
      chk("R7 active kept", active, 1);
      step(1, 14'd9000);
      chk("R7 stamp restart", rec_stamp, 0);
      chk("R7 first after clear", rec_first, 1);
      halt_cmd = 1'b1; run_cmd = 1'b1; @(negedge clk); halt_cmd = 1'b0; run_cmd = 1'b0;
      chk("R6 halt priority", active, 0);
      step(1, 14'd9000);
      chk("R6 halted no record", rec_valid, 0);
      chk("R6 halted count kept", viol_count, 1);
      run_cmd = 1'b1; @(negedge clk); run_cmd = 1'b0;
      step(1, 14'd100);
      chk("R6 resumed record", rec_valid, 1);
      chk("R6 halted strobe not stamped", rec_stamp, 1);
      chk("R6 grouping kept", rec_first, 0);
      chk("R6 resumed count", viol_count, 2);

      // R7 clear on a violating strobe
      clear = 1'b1; step(1, 14'd9000); clear = 1'b0;
      chk("R7 clear suppresses", rec_valid, 0);
      chk("R7 clear count", viol_count, 0);

      // R8 loaded narrow window
      load(14'd100, 14'd0, 16'd10);
      step(1, 14'd100);
      chk("R8 centre in window", rec_valid, 0);
      step(1, 14'd101);
      chk("R8 above", rec_valid, 1);
      chk("R8 above dir", rec_above, 1);
      chk("R4 first narrow", rec_first, 1);
      step(1, 14'd99);
      chk("R8 below", rec_valid, 1);
      chk("R8 below dir", rec_above, 0);
      chk("R3 narrow stamp", rec_stamp, 2);

      // R5 limit zero saturates at once
      pulse_clear();
      load(14'd100, 14'd0, 16'd0);
      chk("R5 zero limit saturated", saturated, 1);
      step(1, 14'd0);
      chk("R5 zero limit no record", rec_valid, 0);

      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule